// File: doc/BRIEF.md
# 16-bit Register-Pair Arithmetic Unit

This unit carries out the 16-bit register-pair operations of an 8-bit processor core: stepping a pair up or down by one, adding a pair to HL, and adding a signed 8-bit displacement to the stack pointer. The caller presents an operation code and its operands together with a one-cycle `start_i`. The unit then takes a fixed number of cycles that depends on the operation and signals completion with a one-cycle `done_o`. In that cycle it presents the 16-bit result, the four flag values and one write-enable per flag. A flag whose enable is low must keep its previous value in the caller's flag register.

The unit is controlled by a small sequencer with three states. In IDLE, `start_i` loads a countdown with the operation's cycle count minus two and moves to RUN (the transition is called accept). RUN loops on itself while the countdown is nonzero and decrements it; when the countdown is zero it moves to DONE. DONE lasts one cycle and returns to IDLE. The arithmetic is evaluated once, at accept, by a single shared adder, and the outcome is held in registers. Register storage, operand fetch and the 8-bit ALU belong to the caller.

Operation codes on `op_i`: 0 = pair increment, 1 = pair decrement, 2 = add pair to HL, 3 = add offset to SP. Flag vectors are ordered {Z, N, H, C}, with Z at bit 3 and C at bit 0.

Top module: `pair_arith_unit`

## Requirements
- R1: Code 0 returns (opa_i + 1) mod 2^16 with all four flag enables low. `done_o` is high in the 2nd cycle after the accepting edge.
- R2: Code 1 returns (opa_i - 1) mod 2^16 with all four flag enables low. `done_o` is high in the 2nd cycle after the accepting edge.
- R3: Code 2 returns (opa_i + opb_i) mod 2^16. H is the carry out of bit 11 and C is the carry out of bit 15. `done_o` is high in the 2nd cycle after the accepting edge.
- R4: For code 2, flag_we_o is 4'b0111: Z is not written, and N, H and C are written. The N value is 0.
- R5: Code 3 sign-extends offs_i to 16 bits and returns the 16-bit truncated sum opa_i + sext(offs_i).
- R6: For code 3, all four enables are high. Z and N are 0, H is the bit-11 carry-out and C is the bit-15 carry-out of that sum. `done_o` is high in the 4th cycle after the accepting edge.
- R7: Operands an operation does not use have no effect. Codes 0 and 1 ignore opb_i and offs_i, code 2 ignores offs_i, and code 3 ignores opb_i.
- R8: `done_o` lasts one cycle. `flag_we_o` is zero whenever `done_o` is low. `result_o` and `flags_o` hold their values until the next accepted operation.
- R9: `start_i` is ignored while `busy_o` is high. The operation in progress completes with its own result, and no second operation starts.
- R10: While `rst_n` is low, `busy_o`, `done_o`, `result_o`, `flags_o` and `flag_we_o` are all zero. A reset during an operation abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request; accepted only when not busy |
| op_i | input | 2 | Operation code (0 inc, 1 dec, 2 add to HL, 3 add to SP) |
| opa_i | input | 16 | Pair, HL or SP operand |
| opb_i | input | 16 | Pair added to HL (code 2 only) |
| offs_i | input | 8 | Signed displacement (code 3 only) |
| busy_o | output | 1 | High from accept through the DONE cycle |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 16 | Result of the last operation |
| flags_o | output | 4 | Flag values {Z,N,H,C} |
| flag_we_o | output | 4 | Flag write-enables {Z,N,H,C}, valid with done_o |

## Verification
The case hardest to reach from the ports is a new request that arrives while an operation is still in flight. The bench launches a 4-cycle stack-pointer addition and then holds `start_i` high with a different increment request through every remaining busy cycle, including the DONE cycle. It then confirms that the first result appears unchanged and that no second completion follows. The carry vectors are chosen so that the bit-11 and bit-15 carries occur alone and together, with negative offsets producing a carry and no half-carry. A reset is also forced in the middle of an operation.

// File: rtl/pair_arith_pkg.sv
package pair_arith_pkg;

    typedef enum logic [1:0] {
        PA_INC    = 2'd0,
        PA_DEC    = 2'd1,
        PA_ADD_HL = 2'd2,
        PA_ADD_SP = 2'd3
    } pa_op_e;

    // Flag vector ordering {Z, N, H, C}
    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } pa_flags_t;

    localparam int PA_NFLAGS = 4;

endpackage

// File: rtl/pair_adder.sv
module pair_adder #(
    parameter int W        = 16,
    parameter int HALF_POS = 12
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         c_half_o,
    output logic         c_full_o
);

    logic [W:0] full_sum;

    assign full_sum = {1'b0, a_i} + {1'b0, b_i};
    assign sum_o    = full_sum[W-1:0];
    assign c_full_o = full_sum[W];

    generate
        if (HALF_POS > 0 && HALF_POS < W) begin : g_half
            logic [HALF_POS:0] low_sum;
            assign low_sum  = {1'b0, a_i[HALF_POS-1:0]} + {1'b0, b_i[HALF_POS-1:0]};
            assign c_half_o = low_sum[HALF_POS];
        end else begin : g_no_half
            assign c_half_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pair_arith_core.sv
module pair_arith_core
    import pair_arith_pkg::*;
#(
    parameter int W        = 16,
    parameter int OW       = 8,
    parameter int HALF_POS = 12
) (
    input  pa_op_e          op_i,
    input  logic [W-1:0]    opa_i,
    input  logic [W-1:0]    opb_i,
    input  logic [OW-1:0]   offs_i,
    output logic [W-1:0]    result_o,
    output pa_flags_t       flags_o,
    output pa_flags_t       we_o
);

    localparam int EXT_W = W - OW;

    logic [W-1:0] addend;
    logic [W-1:0] offs_ext;
    logic         c_half;
    logic         c_full;

    assign offs_ext = {{EXT_W{offs_i[OW-1]}}, offs_i};

    always_comb begin
        unique case (op_i)
            PA_INC:    addend = W'(1);
            PA_DEC:    addend = '1;
            PA_ADD_HL: addend = opb_i;
            PA_ADD_SP: addend = offs_ext;
            default:   addend = '0;
        endcase
    end

    pair_adder #(
        .W        (W),
        .HALF_POS (HALF_POS)
    ) u_adder (
        .a_i      (opa_i),
        .b_i      (addend),
        .sum_o    (result_o),
        .c_half_o (c_half),
        .c_full_o (c_full)
    );

    always_comb begin
        flags_o = '0;
        we_o    = '0;
        unique case (op_i)
            PA_INC, PA_DEC: begin
                flags_o = '0;
                we_o    = '0;
            end
            PA_ADD_HL: begin
                flags_o.h = c_half;
                flags_o.c = c_full;
                we_o.n    = 1'b1;
                we_o.h    = 1'b1;
                we_o.c    = 1'b1;
            end
            PA_ADD_SP: begin
                flags_o.h = c_half;
                flags_o.c = c_full;
                we_o      = '1;
            end
            default: begin
                flags_o = '0;
                we_o    = '0;
            end
        endcase
    end

endmodule

// File: rtl/pair_arith_fsm.sv
module pair_arith_fsm
    import pair_arith_pkg::*;
#(
    parameter int LAT_STEP = 2,
    parameter int LAT_HL   = 2,
    parameter int LAT_SP   = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  pa_op_e op_i,
    output logic   busy_o,
    output logic   done_o,
    output logic   accept_o
);

    localparam int LAT_A   = (LAT_STEP > LAT_HL) ? LAT_STEP : LAT_HL;
    localparam int LAT_MAX = (LAT_A > LAT_SP) ? LAT_A : LAT_SP;
    localparam int CNT_W   = $clog2(LAT_MAX) + 1;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } state_e;

    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        unique case (op_i)
            PA_INC, PA_DEC: load_val = CNT_W'(LAT_STEP - 2);
            PA_ADD_HL:      load_val = CNT_W'(LAT_HL - 2);
            PA_ADD_SP:      load_val = CNT_W'(LAT_SP - 2);
            default:        load_val = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = S_RUN;
                    cnt_d   = load_val;
                end
            end
            S_RUN: begin
                if (cnt_q == '0) begin
                    state_d = S_DONE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        busy_o   = (state_q != S_IDLE);
        done_o   = (state_q == S_DONE);
        accept_o = (state_q == S_IDLE) && start_i;
    end

endmodule

// File: rtl/pair_arith_unit.sv
module pair_arith_unit
    import pair_arith_pkg::*;
#(
    parameter int W        = 16,
    parameter int OW       = 8,
    parameter int HALF_POS = 12,
    parameter int LAT_STEP = 2,
    parameter int LAT_HL   = 2,
    parameter int LAT_SP   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    op_i,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    input  logic [OW-1:0] offs_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  result_o,
    output logic [3:0]    flags_o,
    output logic [3:0]    flag_we_o
);

    pa_op_e    op_e;
    logic      accept;
    logic      done;
    logic [W-1:0] core_result;
    pa_flags_t core_flags;
    pa_flags_t core_we;

    logic [W-1:0] result_q;
    pa_flags_t    flags_q;
    pa_flags_t    we_q;

    assign op_e = pa_op_e'(op_i);

    pair_arith_fsm #(
        .LAT_STEP (LAT_STEP),
        .LAT_HL   (LAT_HL),
        .LAT_SP   (LAT_SP)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .op_i     (op_e),
        .busy_o   (busy_o),
        .done_o   (done),
        .accept_o (accept)
    );

    pair_arith_core #(
        .W        (W),
        .OW       (OW),
        .HALF_POS (HALF_POS)
    ) u_core (
        .op_i     (op_e),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .offs_i   (offs_i),
        .result_o (core_result),
        .flags_o  (core_flags),
        .we_o     (core_we)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            flags_q  <= '0;
            we_q     <= '0;
        end else if (accept) begin
            result_q <= core_result;
            flags_q  <= core_flags;
            we_q     <= core_we;
        end
    end

    always_comb begin
        done_o    = done;
        result_o  = result_q;
        flags_o   = flags_q;
        flag_we_o = done ? we_q : 4'b0000;
    end

endmodule

// File: rtl/pair_arith_chk.sv
module pair_arith_chk #(
    parameter int W        = 16,
    parameter int LAT_STEP = 2,
    parameter int LAT_HL   = 2,
    parameter int LAT_SP   = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [1:0]   op_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] result_o,
    input logic [3:0]   flags_o,
    input logic [3:0]   flag_we_o
);

    logic [1:0] cap_op;
    logic [7:0] lat_cnt;
    logic       acc;
    int         lat_exp;

    assign acc = start_i && !busy_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_op  <= 2'd0;
            lat_cnt <= 8'd0;
        end else if (acc) begin
            cap_op  <= op_i;
            lat_cnt <= 8'd1;
        end else if (busy_o) begin
            lat_cnt <= lat_cnt + 8'd1;
        end
    end

    always_comb begin
        unique case (cap_op)
            2'd2:    lat_exp = LAT_HL;
            2'd3:    lat_exp = LAT_SP;
            default: lat_exp = LAT_STEP;
        endcase
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_we_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (flag_we_o == 4'b0000));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(result_o) && $stable(flags_o)));

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(result_o) && $stable(flags_o)));

    p_step_noflags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (cap_op[1] == 1'b0)) |-> (flag_we_o == 4'b0000));

    p_hl_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (cap_op == 2'd2)) |-> ((flag_we_o == 4'b0111) && !flags_o[2]));

    p_sp_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (cap_op == 2'd3)) |-> ((flag_we_o == 4'b1111) && (flags_o[3:2] == 2'b00)));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(lat_cnt) == lat_exp));

endmodule

bind pair_arith_unit pair_arith_chk #(
    .W        (W),
    .LAT_STEP (LAT_STEP),
    .LAT_HL   (LAT_HL),
    .LAT_SP   (LAT_SP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_i      (op_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .flags_o   (flags_o),
    .flag_we_o (flag_we_o)
);

// File: tb/pair_arith_unit_tb.sv
module pair_arith_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [15:0] opa_i = '0;
    logic [15:0] opb_i = '0;
    logic [7:0]  offs_i = '0;
    logic        busy_o, done_o;
    logic [15:0] result_o;
    logic [3:0]  flags_o, flag_we_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pair_arith_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .offs_i    (offs_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o),
        .flags_o   (flags_o),
        .flag_we_o (flag_we_o)
    );

    // {op, a, b, offs, result, flags{Z,N,H,C}, we{Z,N,H,C}}
    localparam int NV = 13;
    localparam logic [65:0] TBL [NV] = '{
        {2'd0, 16'h1234, 16'hFFFF, 8'hFF, 16'h1235, 4'b0000, 4'b0000},
        {2'd0, 16'hFFFF, 16'h0000, 8'h00, 16'h0000, 4'b0000, 4'b0000},
        {2'd1, 16'h0000, 16'h0000, 8'h00, 16'hFFFF, 4'b0000, 4'b0000},
        {2'd1, 16'h8000, 16'h1234, 8'h80, 16'h7FFF, 4'b0000, 4'b0000},
        {2'd2, 16'h0FFF, 16'h0001, 8'hFF, 16'h1000, 4'b0010, 4'b0111},
        {2'd2, 16'hFFFF, 16'h0001, 8'h00, 16'h0000, 4'b0011, 4'b0111},
        {2'd2, 16'h8000, 16'h8000, 8'h00, 16'h0000, 4'b0001, 4'b0111},
        {2'd2, 16'h1234, 16'h1111, 8'h00, 16'h2345, 4'b0000, 4'b0111},
        {2'd3, 16'hFFF8, 16'hAAAA, 8'h08, 16'h0000, 4'b0011, 4'b1111},
        {2'd3, 16'h1000, 16'h0000, 8'hFF, 16'h0FFF, 4'b0001, 4'b1111},
        {2'd3, 16'h0001, 16'h0000, 8'h80, 16'hFF81, 4'b0000, 4'b1111},
        {2'd3, 16'h0FFF, 16'h0000, 8'h01, 16'h1000, 4'b0010, 4'b1111},
        {2'd3, 16'h7F00, 16'h0000, 8'h7F, 16'h7F7F, 4'b0000, 4'b1111}
    };

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                          input logic [7:0] off, input logic [15:0] res,
                          input logic [3:0] flg, input logic [3:0] we, input string tag_ovr);
        string t_res, t_flg, t_lat;
        int lat_exp;
        int cyc;
        unique case (op)
            2'd0: begin t_res = "R1"; t_flg = "R1"; t_lat = "R1"; end
            2'd1: begin t_res = "R2"; t_flg = "R2"; t_lat = "R2"; end
            2'd2: begin t_res = "R3"; t_flg = "R4"; t_lat = "R3"; end
            default: begin t_res = "R5"; t_flg = "R6"; t_lat = "R6"; end
        endcase
        if (tag_ovr != "") begin
            t_res = tag_ovr; t_flg = tag_ovr;
        end
        lat_exp = (op == 2'd3) ? 4 : 2;
        @(negedge clk);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b; offs_i = off;
        @(negedge clk);
        start_i = 1'b0;
        opa_i = 16'hDEAD; opb_i = 16'hBEEF; offs_i = 8'h5A;
        cyc = 1;
        while (!done_o && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == lat_exp, t_lat, "latency", 16'(cyc), 16'(lat_exp));
        check(result_o == res, t_res, "result", result_o, res);
        check(flags_o == flg, t_flg, "flags", 16'(flags_o), 16'(flg));
        check(flag_we_o == we, t_flg, "flag enables", 16'(flag_we_o), 16'(we));
        @(negedge clk);
        check(!done_o, "R8", "done after pulse", 16'(done_o), 16'd0);
        check(flag_we_o == 4'b0000, "R8", "enables after done", 16'(flag_we_o), 16'd0);
        check(result_o == res, "R8", "result hold", result_o, res);
        check(!busy_o, "R8", "busy after done", 16'(busy_o), 16'd0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o, "R10", "busy/done in reset", {14'd0, busy_o, done_o}, 16'd0);
        check(result_o == 16'h0000, "R10", "result in reset", result_o, 16'h0000);
        check(flags_o == 4'b0000 && flag_we_o == 4'b0000, "R10", "flags in reset",
              {8'd0, flags_o, flag_we_o}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(TBL[i][65:64], TBL[i][63:48], TBL[i][47:32], TBL[i][31:24],
                   TBL[i][23:8], TBL[i][7:4], TBL[i][3:0], "");
        end

        // R7: unused operands carry junk
        run_op(2'd1, 16'h0100, 16'h5A5A, 8'h33, 16'h00FF, 4'b0000, 4'b0000, "R7");
        run_op(2'd2, 16'h0001, 16'h0002, 8'h80, 16'h0003, 4'b0000, 4'b0111, "R7");
        run_op(2'd3, 16'h0010, 16'hFFFF, 8'h10, 16'h0020, 4'b0000, 4'b1111, "R7");

        // R9: start held high through every busy cycle
        begin
            int cyc;
            @(negedge clk);
            start_i = 1'b1; op_i = 2'd3; opa_i = 16'h1000; opb_i = 16'h0000; offs_i = 8'h01;
            @(negedge clk);
            op_i = 2'd0; opa_i = 16'h5555;
            cyc = 1;
            while (!done_o && cyc < 20) begin
                @(negedge clk);
                cyc++;
            end
            check(cyc == 4, "R9", "latency under start", 16'(cyc), 16'd4);
            check(result_o == 16'h1001, "R9", "first result kept", result_o, 16'h1001);
            check(flag_we_o == 4'b1111, "R9", "first op enables", 16'(flag_we_o), 16'hF);
            start_i = 1'b0;
            @(negedge clk);
            check(!busy_o, "R9", "no second accept", 16'(busy_o), 16'd0);
            repeat (3) begin
                @(negedge clk);
                check(!done_o && result_o == 16'h1001, "R9", "no second completion",
                      result_o, 16'h1001);
            end
        end

        // R10: reset in the middle of an operation
        @(negedge clk);
        start_i = 1'b1; op_i = 2'd3; opa_i = 16'h2222; offs_i = 8'h02;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R10", "busy before reset", 16'(busy_o), 16'd1);
        #1 rst_n = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o, "R10", "abandon on reset", {14'd0, busy_o, done_o}, 16'd0);
        check(result_o == 16'h0000 && flag_we_o == 4'b0000, "R10", "cleared on reset",
              result_o, 16'h0000);
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(!done_o, "R10", "no done after reset", 16'(done_o), 16'd0);
        end
        run_op(2'd0, 16'h00FF, 16'h0000, 8'h00, 16'h0100, 4'b0000, 4'b0000, "");

        summary();
    end

endmodule